// File: doc/BRIEF.md
# Power-Good Reset Delay Sequencer

This block turns digitized rail-status flags into two level outputs. The first is a resume reset for the standby rail. It is active low and is released a fixed time after that rail becomes good. The second is a power-good signal for the main rail. It goes high a configurable time after the main rail becomes good. Each rail supplies two comparator flags: one says the rail is above its valid level, the other says it is below its ineffective level. The block applies hysteresis to each pair, so a rail that sits between the two levels keeps its last state.

Delays are counted in ticks. An internal prescaler divides the system clock to produce the ticks, and each delay length is a parameter given in ticks. The power-good delay has a long base (400 ticks by default) or a short base (250 ticks), picked by a range bit. A 2-bit extra code adds 0, 1, 2 or 3 steps of 50 ticks. The standby reset uses 150 ticks. Either output drops as soon as its rail is seen to fail, with no timer on the way down. Each flag passes through a two-flop synchronizer before it is used.

Top module: `pgs_top`

## Requirements
- R1: With `cfg_short` = 0 and `cfg_extra` = 0, `pwr_good` rises only after the main rail has turned valid and PG_LONG_TICKS ticks have then passed. The flags are driven just after a clock edge. Counting that edge's successor as edge 1, the rise is seen after edge 2N+2 or 2N+3, where N is the tick count and TICK_DIV is 2.
- R2: With `cfg_short` = 1, the base delay is PG_SHORT_TICKS instead of PG_LONG_TICKS, and the rise falls in the same window.
- R3: `cfg_extra` = k, for k from 0 to 3, adds k times EXTRA_STEP_TICKS ticks to the power-good delay, whichever base is selected.
- R4: Once the main rail's below-ineffective flag is set, `pwr_good` is low after exactly 4 clock edges: two synchronizer stages, the rail state register and the output register.
- R5: `stby_rst_n` goes high after SB_TICKS ticks of standby-rail validity, in the same window as R1. It goes low 4 edges after the standby below-ineffective flag is set.
- R6: When both flags of a rail are 0, the rail keeps its previous valid or invalid state. An asserted output stays high and a deasserted one stays low.
- R7: If the main rail fails while its delay is counting, the count is discarded. The next rise comes a full delay after the rail is valid again.
- R8: `cfg_short` and `cfg_extra` are sampled only while the main rail is invalid. A change made while the delay counts, or while `pwr_good` is high, takes effect on the next assertion sequence.
- R9: After synchronous reset, `stby_rst_n` and `pwr_good` are both 0.
- R10: If both flags of a rail are set together, the below-ineffective flag wins and the rail is treated as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sb_above_valid | input | 1 | Standby rail is above its valid level |
| sb_below_inval | input | 1 | Standby rail is below its ineffective level |
| mn_above_valid | input | 1 | Main rail is above its valid level |
| mn_below_inval | input | 1 | Main rail is below its ineffective level |
| cfg_short | input | 1 | 1 selects the short power-good base delay |
| cfg_extra | input | 2 | Number of extra delay steps added to the power-good delay |
| stby_rst_n | output | 1 | Standby resume reset, active low |
| pwr_good | output | 1 | Main-rail power-good, active high |

## Verification
Each fault shows up at the ports through the timing of the two outputs.
- A counter that is not cleared when the rail fails makes the next rise early, within one delay period.
- A wrong target latch, or sampling the configuration at the wrong time, moves the rise edge by whole steps of the extra increment.
- A bad hysteresis state flips an output within four cycles of the flags going to the between-levels pattern.
- A missing or extra pipeline stage moves the fall edge off its fixed four-cycle latency at once.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  // Comparator pair for one rail
  typedef struct packed {
    logic below;
    logic above;
  } rail_flags_t;

  // Total delay in ticks for a given configuration
  function automatic int unsigned pg_ticks(input logic short_sel,
                                           input logic [1:0] extra,
                                           input int unsigned long_t,
                                           input int unsigned short_t,
                                           input int unsigned step_t);
    int unsigned base;
    base = short_sel ? short_t : long_t;
    return base + int'(extra) * step_t;
  endfunction
endpackage

// File: rtl/pgs_tick.sv
module pgs_tick #(
  parameter int unsigned DIV = 200000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst || div_cnt == CW'(DIV - 1)) div_cnt <= '0;
    else                                div_cnt <= div_cnt + 1'b1;
  end

  assign tick = (div_cnt == CW'(DIV - 1));
endmodule

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[i] <= 1'b0;
        q[i]    <= 1'b0;
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/pgs_rail.sv
module pgs_rail
  import pgs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  rail_flags_t flags,
  output logic        valid
);
  // Ineffective flag wins; no flag keeps the old state
  always_ff @(posedge clk) begin
    if (rst)              valid <= 1'b0;
    else if (flags.below) valid <= 1'b0;
    else if (flags.above) valid <= 1'b1;
  end
endmodule

// File: rtl/pgs_delay.sv
module pgs_delay #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             valid,
  input  logic [CNT_W-1:0] target_in,
  output logic [CNT_W-1:0] target_q,
  output logic [CNT_W-1:0] cnt,
  output logic             ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      target_q <= '0;
      ready    <= 1'b0;
    end else if (!valid) begin
      cnt      <= '0;
      ready    <= 1'b0;
      target_q <= target_in;
    end else if (!ready && tick) begin
      if (cnt == target_q - 1'b1) ready <= 1'b1;
      else                        cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pgs_top.sv
module pgs_top
  import pgs_pkg::*;
#(
  parameter int unsigned TICK_DIV         = 200000,
  parameter int unsigned SB_TICKS         = 150,
  parameter int unsigned PG_LONG_TICKS    = 400,
  parameter int unsigned PG_SHORT_TICKS   = 250,
  parameter int unsigned EXTRA_STEP_TICKS = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sb_above_valid,
  input  logic       sb_below_inval,
  input  logic       mn_above_valid,
  input  logic       mn_below_inval,
  input  logic       cfg_short,
  input  logic [1:0] cfg_extra,
  output logic       stby_rst_n,
  output logic       pwr_good
);
  localparam int unsigned MAX_BASE = (PG_LONG_TICKS > PG_SHORT_TICKS) ? PG_LONG_TICKS : PG_SHORT_TICKS;
  localparam int unsigned MAX_PG   = MAX_BASE + 3 * EXTRA_STEP_TICKS;
  localparam int unsigned MAX_ALL  = (MAX_PG > SB_TICKS) ? MAX_PG : SB_TICKS;
  localparam int unsigned CNT_W    = $clog2(MAX_ALL + 1);

  logic tick;
  logic [3:0] flags_s;
  rail_flags_t sb_flags, mn_flags;
  logic sb_valid, mn_valid;
  logic [CNT_W-1:0] sb_tgt, sb_cnt, mn_tgt, mn_cnt, mn_tgt_in;

  pgs_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  pgs_sync #(.W(4)) u_sync (
    .clk(clk), .rst(rst),
    .d({mn_below_inval, mn_above_valid, sb_below_inval, sb_above_valid}),
    .q(flags_s)
  );

  assign sb_flags = '{below: flags_s[1], above: flags_s[0]};
  assign mn_flags = '{below: flags_s[3], above: flags_s[2]};

  pgs_rail u_sb_rail (.clk(clk), .rst(rst), .flags(sb_flags), .valid(sb_valid));
  pgs_rail u_mn_rail (.clk(clk), .rst(rst), .flags(mn_flags), .valid(mn_valid));

  assign mn_tgt_in = CNT_W'(pg_ticks(cfg_short, cfg_extra, PG_LONG_TICKS,
                                     PG_SHORT_TICKS, EXTRA_STEP_TICKS));

  pgs_delay #(.CNT_W(CNT_W)) u_sb_dly (
    .clk(clk), .rst(rst), .tick(tick), .valid(sb_valid),
    .target_in(CNT_W'(SB_TICKS)), .target_q(sb_tgt), .cnt(sb_cnt),
    .ready(stby_rst_n)
  );

  pgs_delay #(.CNT_W(CNT_W)) u_mn_dly (
    .clk(clk), .rst(rst), .tick(tick), .valid(mn_valid),
    .target_in(mn_tgt_in), .target_q(mn_tgt), .cnt(mn_cnt),
    .ready(pwr_good)
  );
endmodule

// File: rtl/pgs_chk.sv
module pgs_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       flags_s,
  input logic             sb_valid,
  input logic             mn_valid,
  input logic [CNT_W-1:0] mn_cnt,
  input logic [CNT_W-1:0] mn_tgt,
  input logic [CNT_W-1:0] sb_cnt,
  input logic [CNT_W-1:0] sb_tgt,
  input logic             stby_rst_n,
  input logic             pwr_good
);
  // R4: main rail invalid forces power-good low on the next edge
  a_r4_pg_drop: assert property (@(posedge clk) disable iff (rst)
    !mn_valid |=> !pwr_good);

  // R5: standby rail invalid forces the resume reset active
  a_r5_sb_drop: assert property (@(posedge clk) disable iff (rst)
    !sb_valid |=> !stby_rst_n);

  // R1: power-good only rises while the rail has been valid
  a_r1_rise_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_good) |-> $past(mn_valid));

  // R7: counter never passes its target while counting
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    mn_valid |-> (mn_cnt < mn_tgt));

  a_r5_sb_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    sb_valid |-> (sb_cnt < sb_tgt));

  // R8: target frozen while the rail stays valid
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (mn_valid && $past(mn_valid)) |-> $stable(mn_tgt));

  // R6: no comparator flag keeps the rail state
  a_r6_hold_mn: assert property (@(posedge clk) disable iff (rst)
    (!flags_s[3] && !flags_s[2]) |=> $stable(mn_valid));

  // R10: ineffective flag has priority
  a_r10_below_wins: assert property (@(posedge clk) disable iff (rst)
    flags_s[3] |=> !mn_valid);
endmodule

bind pgs_top pgs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .flags_s(flags_s), .sb_valid(sb_valid),
  .mn_valid(mn_valid), .mn_cnt(mn_cnt), .mn_tgt(mn_tgt),
  .sb_cnt(sb_cnt), .sb_tgt(sb_tgt), .stby_rst_n(stby_rst_n),
  .pwr_good(pwr_good)
);

// File: tb/sim_pgs_top.sv
`timescale 1ns/1ps
module sim_pgs_top;
  localparam int DIV = 2, SB = 3, LONG = 8, SHORT = 5, STEP = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic sb_above = 0, sb_below = 0, mn_above = 0, mn_below = 0;
  logic cfg_short = 0;
  logic [1:0] cfg_extra = 0;
  logic stby_rst_n, pwr_good;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgs_top #(.TICK_DIV(DIV), .SB_TICKS(SB), .PG_LONG_TICKS(LONG),
            .PG_SHORT_TICKS(SHORT), .EXTRA_STEP_TICKS(STEP)) u0 (
    .clk(clk), .rst(rst), .sb_above_valid(sb_above), .sb_below_inval(sb_below),
    .mn_above_valid(mn_above), .mn_below_inval(mn_below),
    .cfg_short(cfg_short), .cfg_extra(cfg_extra),
    .stby_rst_n(stby_rst_n), .pwr_good(pwr_good));

  task automatic check(input string req, input int act, input int exp_lo, input int exp_hi);
    checks++;
    if (act < exp_lo || act > exp_hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  // Count edges until the selected output reaches lvl (sampled at negedge)
  task automatic wait_lvl(input bit sel_pg, input bit lvl, input int start, output int edges);
    edges = start;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); edges++;
      @(negedge clk);
      if ((sel_pg ? pwr_good : stby_rst_n) == lvl) return;
    end
    edges = -1;
  endtask

  task automatic mn_fail();
    int e;
    mn_above = 0; mn_below = 1;
    wait_lvl(1, 0, 0, e);
    check("R4 fall latency", e, 4, 4);
    mn_below = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int e, n;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 reset pwr_good", pwr_good, 0, 0);
    check("R9 reset stby_rst_n", stby_rst_n, 0, 0);

    // R5 standby release
    sb_above = 1;
    wait_lvl(0, 1, 0, e);
    check("R5 stby release", e, 2*SB+2, 2*SB+3);

    // R1 R2 R3 sweep over range and extra codes
    for (int s = 0; s < 2; s++) begin
      for (int x = 0; x < 4; x++) begin
        cfg_short = s[0]; cfg_extra = x[1:0];
        n = (s ? SHORT : LONG) + x * STEP;
        mn_above = 1;
        wait_lvl(1, 1, 0, e);
        check(s ? "R2 short range R3 extra" : "R1 long range R3 extra", e, 2*n+2, 2*n+3);
        mn_fail();
      end
    end
    cfg_short = 0; cfg_extra = 0;

    // R6 hysteresis: invalid holds with no flags
    repeat (40) @(negedge clk);
    check("R6 hold low", pwr_good, 0, 0);
    mn_above = 1;
    wait_lvl(1, 1, 0, e);
    check("R1 rise after hold", e, 2*LONG+2, 2*LONG+3);
    mn_above = 0;
    repeat (40) @(negedge clk);
    check("R6 hold high", pwr_good, 1, 1);
    mn_fail();

    // R10 both flags set: treated invalid
    mn_above = 1; mn_below = 1;
    repeat (40) @(negedge clk);
    check("R10 below wins", pwr_good, 0, 0);
    mn_above = 0; mn_below = 0;
    repeat (4) @(negedge clk);

    // R7 restart from zero after mid-count failure
    mn_above = 1;
    repeat (10) @(negedge clk);
    check("R7 not early", pwr_good, 0, 0);
    mn_above = 0; mn_below = 1;
    repeat (6) @(negedge clk);
    mn_below = 0; mn_above = 1;
    wait_lvl(1, 1, 0, e);
    check("R7 full delay", e, 2*LONG+2, 2*LONG+3);
    mn_fail();

    // R8 config change during count has no effect now
    mn_above = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    cfg_short = 1; cfg_extra = 3;
    wait_lvl(1, 1, 5, e);
    check("R8 old cfg used", e, 2*LONG+2, 2*LONG+3);
    cfg_short = 0; cfg_extra = 0;
    repeat (4) @(negedge clk);
    cfg_short = 1; cfg_extra = 3;
    mn_fail();
    n = SHORT + 3 * STEP;
    mn_above = 1;
    wait_lvl(1, 1, 0, e);
    check("R8 new cfg next sequence", e, 2*n+2, 2*n+3);

    // R5 standby drop, power-good unaffected path
    sb_above = 0; sb_below = 1;
    wait_lvl(0, 0, 0, e);
    check("R5 stby fall", e, 4, 4);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule